// File: doc/BRIEF.md
# Split Sequential Next-PC Adder

This block computes the address of the next sequential instruction for a fetch stage whose instructions are 1, 2, 5 or 6 bytes long. The opcode byte may be followed by an optional register-specifier byte and an optional four-byte constant word. Two decode flags report which of these trailing fields are present.

The adder is split to shorten the critical path. The upper 29 bits of the program counter are incremented as soon as the PC is known, so the incrementer runs in parallel with the instruction memory read. Once the decode flags settle, only a 3-bit addition of the instruction length to the low bits remains. The carry out of that small adder then chooses between the unmodified upper part and the pre-incremented upper part.

The block is purely combinational, holds no state and has no clock.

Top module: `fetch_pc_incr`

## Requirements
- R1: With both flags low, the instruction length is 1 byte and `next_pc` equals `pc + 1`.
- R2: With only `has_reg_byte` high, the length is 2 bytes.
- R3: With only `has_const_word` high, the length is 5 bytes; with both flags high, it is 6 bytes.
- R4: For every PC and every flag combination, `next_pc` equals `pc` plus the length, modulo 2^32.
- R5: `next_pc[2:0]` equals `(pc[2:0] + length) mod 8`.
- R6: `next_pc[31:3]` equals `pc[31:3]` when `pc[2:0] + length` is below 8, and equals `pc[31:3] + 1` otherwise.
- R7: An addition that crosses 0xFFFFFFFF wraps to a small address with the upper 29 bits equal to zero.
- R8: The output depends only on the present inputs; the same inputs give the same `next_pc` whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| has_reg_byte_i | input | 1 | Decode flag: a register-specifier byte follows the opcode |
| has_const_i | input | 1 | Decode flag: a 4-byte constant word is present |
| next_pc_o | output | 32 | Address of the next sequential instruction |

## Verification
The four flag combinations are applied at low-bit offsets that keep the short sum below 8, where only the low bits may move. They are also applied at offsets that push the sum to 8 or more, which shows whether the carry actually selects the incremented upper part. PCs near 0xFFFFFFFF, and with long runs of ones in the upper field, separate a correct wrap from a truncated or mis-sized incrementer. An exhaustive sweep of the three low bits against all flag pairs, random PCs, and a repeated vector after unrelated history cover the remaining space and the absence of state.

// File: rtl/fetch_pc_incr.sv
module fetch_pc_incr #(
  parameter int PC_W        = 32,
  parameter int LO_W        = 3,
  parameter int REG_BYTES   = 1,
  parameter int CONST_BYTES = 4
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            has_reg_byte_i,
  input  logic            has_const_i,
  output logic [PC_W-1:0] next_pc_o
);

  localparam int HI_W = PC_W - LO_W;

  logic [HI_W-1:0] hi, hi_inc, hi_sel;
  logic [LO_W-1:0] lo, len;
  logic [LO_W:0]   lo_sum;

  // early path: depends only on the PC
  assign hi     = pc_i[PC_W-1:LO_W];
  assign hi_inc = hi + HI_W'(1);

  // late path: waits for the decode flags
  assign lo  = pc_i[LO_W-1:0];
  assign len = LO_W'(1)
             + (has_reg_byte_i ? LO_W'(REG_BYTES)   : '0)
             + (has_const_i    ? LO_W'(CONST_BYTES) : '0);

  assign lo_sum = {1'b0, lo} + {1'b0, len};

  assign hi_sel    = lo_sum[LO_W] ? hi_inc : hi;
  assign next_pc_o = {hi_sel, lo_sum[LO_W-1:0]};

endmodule

// File: rtl/fetch_pc_incr_chk.sv
module fetch_pc_incr_chk #(
  parameter int PC_W = 32,
  parameter int LO_W = 3
) (
  input logic [PC_W-1:0] pc_i,
  input logic            has_reg_byte_i,
  input logic            has_const_i,
  input logic [PC_W-1:0] next_pc_o
);

  localparam int HI_W = PC_W - LO_W;

  logic [3:0]      exp_len;
  logic [PC_W-1:0] ref_pc;
  logic [4:0]      lo_tot;
  logic [HI_W-1:0] hi_in, hi_out;

  always_comb begin
    case ({has_const_i, has_reg_byte_i})
      2'b00:   exp_len = 4'd1;
      2'b01:   exp_len = 4'd2;
      2'b10:   exp_len = 4'd5;
      default: exp_len = 4'd6;
    endcase
    ref_pc = pc_i + PC_W'(exp_len);
    lo_tot = 5'(pc_i[LO_W-1:0]) + 5'(exp_len);
    hi_in  = pc_i[PC_W-1:LO_W];
    hi_out = next_pc_o[PC_W-1:LO_W];
    if (!$isunknown({pc_i, has_reg_byte_i, has_const_i, next_pc_o})) begin
      AST_FULL_SUM: assert (next_pc_o == ref_pc) else $error("sum mismatch"); // R4
      AST_LOW_FIELD: assert (next_pc_o[LO_W-1:0] == lo_tot[LO_W-1:0]) else $error("low field"); // R5
      AST_HIGH_HOLD: assert (lo_tot >= 5'd8 || hi_out == hi_in) else $error("high moved"); // R6
      AST_HIGH_STEP: assert (lo_tot < 5'd8 || hi_out == hi_in + HI_W'(1)) else $error("high not stepped"); // R6
      AST_WRAP_ZERO: assert (!(&hi_in && lo_tot >= 5'd8) || hi_out == '0) else $error("wrap"); // R7
    end
  end

endmodule

bind fetch_pc_incr fetch_pc_incr_chk #(.PC_W(PC_W), .LO_W(LO_W)) u_chk (
  .pc_i(pc_i),
  .has_reg_byte_i(has_reg_byte_i),
  .has_const_i(has_const_i),
  .next_pc_o(next_pc_o)
);

// File: tb/sim_fetch_pc_incr.sv
module sim_fetch_pc_incr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc;
  logic        rb, cw;
  logic [31:0] npc;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fetch_pc_incr u0 (
    .pc_i(pc),
    .has_reg_byte_i(rb),
    .has_const_i(cw),
    .next_pc_o(npc)
  );

  // {pc, reg flag, const flag, expected next pc}
  localparam int NV = 16;
  localparam logic [65:0] VEC [NV] = '{
    {32'h0000_0000, 1'b0, 1'b0, 32'h0000_0001},  // R1
    {32'h0000_1000, 1'b1, 1'b0, 32'h0000_1002},  // R2
    {32'h0000_1000, 1'b0, 1'b1, 32'h0000_1005},  // R3
    {32'h0000_1000, 1'b1, 1'b1, 32'h0000_1006},  // R3
    {32'h0000_0007, 1'b0, 1'b0, 32'h0000_0008},  // R6 carry
    {32'h0000_0007, 1'b1, 1'b1, 32'h0000_000D},  // R6
    {32'h0000_0002, 1'b1, 1'b1, 32'h0000_0008},  // R6 sum exactly 8
    {32'h0000_0001, 1'b1, 1'b1, 32'h0000_0007},  // R5 sum 7, no carry
    {32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0000_0000},  // R7
    {32'hFFFF_FFFA, 1'b1, 1'b1, 32'h0000_0000},  // R7
    {32'hFFFF_FFFC, 1'b0, 1'b1, 32'h0000_0001},  // R7
    {32'h7FFF_FFFB, 1'b1, 1'b1, 32'h8000_0001},  // R4 long ripple
    {32'h1234_5678, 1'b1, 1'b0, 32'h1234_567A},  // R4
    {32'hDEAD_BEEF, 1'b0, 1'b1, 32'hDEAD_BEF4},  // R4
    {32'h00FF_FFFD, 1'b1, 1'b1, 32'h0100_0003},  // R4
    {32'hFFFF_FFF9, 1'b1, 1'b1, 32'hFFFF_FFFF}   // R5 top without wrap
  };

  function automatic logic [31:0] ref_next(logic [31:0] p, logic r, logic c);
    int len;
    len = 1 + (r ? 1 : 0) + (c ? 4 : 0);
    return p + 32'(len);
  endfunction

  task automatic apply(logic [31:0] p, logic r, logic c);
    @(negedge clk);
    pc = p; rb = r; cw = c;
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s pc=%h flags=%b%b got=%h exp=%h", tag, pc, rb, cw, got, exp);
    end
  endtask

  initial begin
    pc = '0; rb = 1'b0; cw = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    chk("reset R1", npc, 32'h1);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][65:34], VEC[i][33], VEC[i][32]);
      chk($sformatf("table[%0d] R4", i), npc, VEC[i][31:0]);
    end

    // R5 R6: every low offset against every flag pair
    for (int lo = 0; lo < 8; lo++) begin
      for (int f = 0; f < 4; f++) begin
        apply({29'h0ABC_DEF1, 3'(lo)}, f[0], f[1]);
        chk("sweep R5", {29'h0, npc[2:0]}, {29'h0, ref_next(pc, rb, cw)[2:0]});
        chk("sweep R6", {3'h0, npc[31:3]}, {3'h0, ref_next(pc, rb, cw)[31:3]});
      end
    end

    // R4: random PCs
    for (int k = 0; k < 200; k++) begin
      automatic logic [31:0] p = $urandom;
      automatic logic [1:0]  f = 2'($urandom);
      apply(p, f[0], f[1]);
      chk("random R4", npc, ref_next(p, f[0], f[1]));
    end

    // R8: same inputs after different history
    apply(32'h0000_4003, 1'b1, 1'b1);
    chk("history R8", npc, 32'h0000_4009);
    apply(32'hFFFF_FFFF, 1'b0, 1'b1);
    chk("history R7", npc, 32'h0000_0004);
    apply(32'h0000_4003, 1'b1, 1'b1);
    chk("history R8", npc, 32'h0000_4009);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R8 got=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule